// File: doc/BRIEF.md
# Video Controller Command Port Decoder

This block sits behind the 16-bit control port of a tile-based video display controller. Each word written to the port is sorted into one of two kinds. It is either a single-word register write, which is forwarded as a one-cycle strobe to the register file, or one half of a two-word access command. An access command builds a 16-bit access address and a 6-bit access code. A pending flag records that the first half has arrived and the second half is awaited. The top two address bits given by a second word are kept and reused by later first words.

The block keeps a private copy of the DMA-enable bit and the DMA-mode field, taken from its own register strobes. When a second word carries the DMA code bit and DMA is enabled, the block raises a start request with the transfer kind. A fill-type request is held armed until the next data-port write. The block also forms the word a control-port read returns, with a sticky sprite-collision flag and fixed FIFO bits. Reads, data-port accesses and control reads each carry their side effects on the pending flag and the collision flag.

Top module: `vcmd_port`

## Requirements
- R1: With pending clear, a control word whose bits 15:14 are 2'b10 is a register write. One cycle later `reg_we` pulses for exactly one cycle, with `reg_idx` = word bits 12:8 and `reg_val` = word bits 7:0. Pending stays clear.
- R2: With pending clear, any control word loads address bits 13:0 from word bits 13:0, address bits 15:14 from the latched pair, and code bits 1:0 from word bits 15:14, and keeps code bits 5:2. This holds for register writes too. A word that is not a register write sets pending.
- R3: With pending set, a control word clears pending. It loads address bits 15:14 from word bits 1:0 and code bits 5:2 from word bits 7:4, keeps address bits 13:0 and code bits 1:0, and latches word bits 1:0 for later first words.
- R4: A second word starts or arms a DMA only when word bit 7 (the new code bit 5) is 1 and the most recent in-range write to register 1 had value bit 4 set. A first word never starts a DMA.
- R5: The DMA kind is value bits 7:6 of the most recent write to register 23. Kinds 2'b00, 2'b01 (external bus transfer) and 2'b11 (in-memory copy) pulse `dma_start` for one cycle, one cycle after the second word, with `dma_kind` equal to that field. Kind 2'b10 sets `fill_armed` instead.
- R6: While `fill_armed` is 1, the next data-port write pulses `dma_start` with `dma_kind` = 2'b10 one cycle later and clears `fill_armed`.
- R7: The read word has bit 9 = 1, bit 6 = 0, bits 15:10 = 0, bit 5 = the sticky collision flag, and bits 8:7 and 4:0 from `live_flags`. A collision event sets the flag. A control read clears the flag and the pending flag; an event in the same cycle wins over the clear.
- R8: Any data-port read or write clears the pending flag.
- R9: Register writes whose index is above 23 produce no strobe and change neither the DMA-enable copy nor the DMA-mode copy.
- R10: Synchronous active-high reset clears address, latched pair, code, pending, the collision flag, the DMA copies, the fill arming and all strobes.
- R11: A control write in the same cycle as a control read or data-port access takes precedence. That read or access has no effect on pending, and such a data write does not fire an armed fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Control-port write strobe |
| ctl_wdata | input | 16 | Control-port write word |
| ctl_rd | input | 1 | Control-port read strobe |
| ctl_rdata | output | 16 | Status word returned by a control read |
| dat_wr | input | 1 | Data-port write strobe |
| dat_rd | input | 1 | Data-port read strobe |
| live_flags | input | 9 | Live status bits from raster timing |
| collide_evt | input | 1 | Sprite collision event |
| reg_we | output | 1 | Register write strobe |
| reg_idx | output | 5 | Register index |
| reg_val | output | 8 | Register value |
| acc_addr | output | 16 | Access address register |
| acc_code | output | 6 | Access code register |
| pending | output | 1 | Second command word awaited |
| dma_start | output | 1 | DMA start pulse |
| dma_kind | output | 2 | DMA transfer kind |
| fill_armed | output | 1 | Fill waiting for a data write |

## Verification
A wrong pending flag shows on the very next control word, because that word is then decoded as the wrong half. The address and code outputs show the error one cycle later, and a register write may be misread as a command. A stale latched address pair only appears on the first word of the following command. A stale DMA-enable or mode copy stays hidden until a later second word with the DMA code bit, so the bench compares every output each cycle against a model that tracks these copies.

// File: rtl/vcmd_pkg.sv
package vcmd_pkg;
   localparam int WORD_W = 16;

   typedef enum logic [1:0] {
      KIND_BUS_A = 2'b00,
      KIND_BUS_B = 2'b01,
      KIND_FILL  = 2'b10,
      KIND_COPY  = 2'b11
   } dma_kind_e;
endpackage

// File: rtl/vcmd_assemble.sv
// Command word assembly: address, code, latched high address pair, pending.
module vcmd_assemble
   import vcmd_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int CODE_W = 6
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr,
   input  logic [WORD_W-1:0] wdata,
   input  logic              clr,
   output logic              is_reg,
   output logic              second,
   output logic [ADDR_W-1:0] addr,
   output logic [CODE_W-1:0] code,
   output logic              pending
);
   localparam int LOW_W  = ADDR_W - 2;
   localparam int CHI_W  = CODE_W - 2;
   localparam int CHI_LO = 4;

   generate
      if (ADDR_W != WORD_W) begin : g_bad_addr
         $error("vcmd_assemble: ADDR_W must equal the port word width");
      end
      if (CODE_W != 6) begin : g_bad_code
         $error("vcmd_assemble: CODE_W must be 6");
      end
   endgenerate

   logic [1:0] hi_latch;

   assign is_reg = !pending && (wdata[WORD_W-1 -: 2] == 2'b10);
   assign second = wr && pending;

   always_ff @(posedge clk) begin
      if (rst) begin
         addr     <= '0;
         code     <= '0;
         pending  <= 1'b0;
         hi_latch <= 2'b00;
      end else if (wr) begin
         if (!pending) begin
            addr    <= {hi_latch, wdata[LOW_W-1:0]};
            code    <= {code[CODE_W-1:2], wdata[WORD_W-1 -: 2]};
            pending <= !is_reg;
         end else begin
            pending  <= 1'b0;
            addr     <= {wdata[1:0], addr[LOW_W-1:0]};
            code     <= {wdata[CHI_LO+CHI_W-1:CHI_LO], code[1:0]};
            hi_latch <= wdata[1:0];
         end
      end else if (clr) begin
         pending <= 1'b0;
      end
   end
endmodule

// File: rtl/vcmd_regtap.sv
// Register write strobe plus private copies of the DMA enable and mode.
module vcmd_regtap #(
   parameter int IDX_W    = 5,
   parameter int VAL_W    = 8,
   parameter int REG_LAST = 23,
   parameter int EN_REG   = 1,
   parameter int EN_BIT   = 4,
   parameter int MODE_REG = 23
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             hit,
   input  logic [IDX_W-1:0] idx,
   input  logic [VAL_W-1:0] val,
   output logic             reg_we,
   output logic [IDX_W-1:0] reg_idx,
   output logic [VAL_W-1:0] reg_val,
   output logic             dma_en,
   output logic [1:0]       dma_mode
);
   localparam logic [IDX_W-1:0] LAST_I = IDX_W'(REG_LAST);
   localparam logic [IDX_W-1:0] EN_I   = IDX_W'(EN_REG);
   localparam logic [IDX_W-1:0] MODE_I = IDX_W'(MODE_REG);

   generate
      if (REG_LAST >= (1 << IDX_W)) begin : g_bad_last
         $error("vcmd_regtap: REG_LAST does not fit IDX_W");
      end
      if (EN_BIT >= VAL_W || VAL_W < 2) begin : g_bad_bit
         $error("vcmd_regtap: EN_BIT or VAL_W out of range");
      end
      if (EN_REG > REG_LAST || MODE_REG > REG_LAST) begin : g_bad_reg
         $error("vcmd_regtap: control registers must be in range");
      end
   endgenerate

   logic take;
   assign take = hit && (idx <= LAST_I);

   always_ff @(posedge clk) begin
      if (rst) begin
         reg_we   <= 1'b0;
         reg_idx  <= '0;
         reg_val  <= '0;
         dma_en   <= 1'b0;
         dma_mode <= 2'b00;
      end else begin
         reg_we <= take;
         if (take) begin
            reg_idx <= idx;
            reg_val <= val;
            if (idx == EN_I)   dma_en   <= val[EN_BIT];
            if (idx == MODE_I) dma_mode <= val[VAL_W-1 -: 2];
         end
      end
   end
endmodule

// File: rtl/vcmd_dma_arm.sv
// DMA start decoding and fill arming.
module vcmd_dma_arm
   import vcmd_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  logic       second,
   input  logic       code_dma,
   input  logic       dma_en,
   input  logic [1:0] dma_mode,
   input  logic       dat_wr_ok,
   output logic       dma_start,
   output logic [1:0] dma_kind,
   output logic       fill_armed
);
   dma_kind_e mode_e;
   logic      trig, fire, is_fill;

   assign mode_e  = dma_kind_e'(dma_mode);
   assign trig    = second && code_dma && dma_en;
   assign is_fill = (mode_e == KIND_FILL);
   assign fire    = dat_wr_ok && fill_armed;

   always_ff @(posedge clk) begin
      if (rst) begin
         dma_start  <= 1'b0;
         dma_kind   <= KIND_BUS_A;
         fill_armed <= 1'b0;
      end else begin
         dma_start <= (trig && !is_fill) || fire;
         if (trig && !is_fill)  dma_kind <= mode_e;
         else if (fire)         dma_kind <= KIND_FILL;
         if (trig && is_fill)   fill_armed <= 1'b1;
         else if (fire)         fill_armed <= 1'b0;
      end
   end
endmodule

// File: rtl/vcmd_status.sv
// Status word builder with a sticky collision flag.
module vcmd_status #(
   parameter int WORD_W    = 16,
   parameter int COLL_BIT  = 5,
   parameter int OVF_BIT   = 6,
   parameter int EMPTY_BIT = 9
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 rd,
   input  logic [EMPTY_BIT-1:0] live,
   input  logic                 collide_evt,
   output logic [WORD_W-1:0]    rdata
);
   generate
      if (EMPTY_BIT >= WORD_W || COLL_BIT >= EMPTY_BIT || OVF_BIT >= EMPTY_BIT
          || COLL_BIT == OVF_BIT) begin : g_bad_bits
         $error("vcmd_status: status bit positions inconsistent");
      end
   endgenerate

   logic coll;

   always_ff @(posedge clk) begin
      if (rst)              coll <= 1'b0;
      else if (collide_evt) coll <= 1'b1;
      else if (rd)          coll <= 1'b0;
   end

   logic unused_live;
   assign unused_live = live[COLL_BIT] ^ live[OVF_BIT];

   for (genvar b = 0; b < WORD_W; b++) begin : g_bit
      if (b == EMPTY_BIT) begin : g_one
         assign rdata[b] = 1'b1;
      end else if (b > EMPTY_BIT || b == OVF_BIT) begin : g_zero
         assign rdata[b] = 1'b0;
      end else if (b == COLL_BIT) begin : g_coll
         assign rdata[b] = coll;
      end else begin : g_live
         assign rdata[b] = live[b];
      end
   end
endmodule

// File: rtl/vcmd_port.sv
module vcmd_port
   import vcmd_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int CODE_W    = 6,
   parameter int IDX_W     = 5,
   parameter int VAL_W     = 8,
   parameter int REG_LAST  = 23,
   parameter int EN_REG    = 1,
   parameter int EN_BIT    = 4,
   parameter int MODE_REG  = 23,
   parameter int EMPTY_BIT = 9
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 ctl_wr,
   input  logic [15:0]          ctl_wdata,
   input  logic                 ctl_rd,
   output logic [15:0]          ctl_rdata,
   input  logic                 dat_wr,
   input  logic                 dat_rd,
   input  logic [EMPTY_BIT-1:0] live_flags,
   input  logic                 collide_evt,
   output logic                 reg_we,
   output logic [IDX_W-1:0]     reg_idx,
   output logic [VAL_W-1:0]     reg_val,
   output logic [ADDR_W-1:0]    acc_addr,
   output logic [CODE_W-1:0]    acc_code,
   output logic                 pending,
   output logic                 dma_start,
   output logic [1:0]           dma_kind,
   output logic                 fill_armed
);
   localparam int IDX_LO   = 8;
   localparam int CODE_DMA = 4 + CODE_W - 3;

   generate
      if (IDX_LO + IDX_W > WORD_W - 3 || VAL_W > IDX_LO) begin : g_bad_fields
         $error("vcmd_port: register field widths do not fit the word");
      end
   endgenerate

   logic       is_reg, second, clr, dma_en, dat_wr_ok;
   logic [1:0] dma_mode;

   assign clr       = ctl_rd || dat_wr || dat_rd;
   assign dat_wr_ok = dat_wr && !ctl_wr;

   vcmd_assemble #(.ADDR_W(ADDR_W), .CODE_W(CODE_W)) u_asm (
      .clk(clk), .rst(rst), .wr(ctl_wr), .wdata(ctl_wdata), .clr(clr),
      .is_reg(is_reg), .second(second), .addr(acc_addr), .code(acc_code),
      .pending(pending)
   );

   vcmd_regtap #(
      .IDX_W(IDX_W), .VAL_W(VAL_W), .REG_LAST(REG_LAST),
      .EN_REG(EN_REG), .EN_BIT(EN_BIT), .MODE_REG(MODE_REG)
   ) u_reg (
      .clk(clk), .rst(rst), .hit(ctl_wr && is_reg),
      .idx(ctl_wdata[IDX_LO+IDX_W-1:IDX_LO]), .val(ctl_wdata[VAL_W-1:0]),
      .reg_we(reg_we), .reg_idx(reg_idx), .reg_val(reg_val),
      .dma_en(dma_en), .dma_mode(dma_mode)
   );

   vcmd_dma_arm u_dma (
      .clk(clk), .rst(rst), .second(second), .code_dma(ctl_wdata[CODE_DMA]),
      .dma_en(dma_en), .dma_mode(dma_mode), .dat_wr_ok(dat_wr_ok),
      .dma_start(dma_start), .dma_kind(dma_kind), .fill_armed(fill_armed)
   );

   vcmd_status #(.WORD_W(WORD_W), .EMPTY_BIT(EMPTY_BIT)) u_stat (
      .clk(clk), .rst(rst), .rd(ctl_rd), .live(live_flags),
      .collide_evt(collide_evt), .rdata(ctl_rdata)
   );
endmodule

// File: rtl/vcmd_port_chk.sv
module vcmd_port_chk (
   input logic        clk,
   input logic        rst,
   input logic        ctl_wr,
   input logic [15:0] ctl_wdata,
   input logic        ctl_rd,
   input logic [15:0] ctl_rdata,
   input logic        dat_wr,
   input logic        dat_rd,
   input logic        reg_we,
   input logic [4:0]  reg_idx,
   input logic [7:0]  reg_val,
   input logic [15:0] acc_addr,
   input logic [5:0]  acc_code,
   input logic        pending,
   input logic        dma_start,
   input logic [1:0]  dma_kind,
   input logic        fill_armed
);
   p_regwr_r1: assert property (@(posedge clk) disable iff (rst)
      ctl_wr && !pending && ctl_wdata[15:14] == 2'b10 && ctl_wdata[12:8] <= 5'd23
      |=> reg_we && reg_idx == $past(ctl_wdata[12:8]) &&
          reg_val == $past(ctl_wdata[7:0]) && !pending);

   p_first_word_r2: assert property (@(posedge clk) disable iff (rst)
      ctl_wr && !pending && ctl_wdata[15:14] != 2'b10
      |=> pending && acc_addr[13:0] == $past(ctl_wdata[13:0]) &&
          acc_addr[15:14] == $past(acc_addr[15:14]) &&
          acc_code[1:0] == $past(ctl_wdata[15:14]) &&
          acc_code[5:2] == $past(acc_code[5:2]));

   p_second_word_r3: assert property (@(posedge clk) disable iff (rst)
      ctl_wr && pending
      |=> !pending && acc_addr[15:14] == $past(ctl_wdata[1:0]) &&
          acc_code[5:2] == $past(ctl_wdata[7:4]) &&
          acc_addr[13:0] == $past(acc_addr[13:0]) &&
          acc_code[1:0] == $past(acc_code[1:0]));

   p_no_dma_gate_r4: assert property (@(posedge clk) disable iff (rst)
      ctl_wr && (!pending || !ctl_wdata[7]) |=> !dma_start);

   p_fill_fire_r6: assert property (@(posedge clk) disable iff (rst)
      dat_wr && !ctl_wr && fill_armed |=> dma_start && dma_kind == 2'b10 && !fill_armed);

   p_read_word_r7: assert property (@(posedge clk) disable iff (rst)
      ctl_rd |-> ctl_rdata[9] && !ctl_rdata[6] && ctl_rdata[15:10] == 6'd0);

   p_read_clears_r7: assert property (@(posedge clk) disable iff (rst)
      ctl_rd && !ctl_wr |=> !pending);

   p_data_clears_r8: assert property (@(posedge clk) disable iff (rst)
      (dat_wr || dat_rd) && !ctl_wr |=> !pending);

   p_high_idx_r9: assert property (@(posedge clk) disable iff (rst)
      ctl_wr && !pending && ctl_wdata[15:14] == 2'b10 && ctl_wdata[12:8] > 5'd23
      |=> !reg_we);

   p_reset_r10: assert property (@(posedge clk)
      $past(rst) |-> !pending && !fill_armed && !dma_start && !reg_we && acc_addr == 16'd0);
endmodule

bind vcmd_port vcmd_port_chk u_chk (
   .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_rd(ctl_rd),
   .ctl_rdata(ctl_rdata), .dat_wr(dat_wr), .dat_rd(dat_rd), .reg_we(reg_we),
   .reg_idx(reg_idx), .reg_val(reg_val), .acc_addr(acc_addr), .acc_code(acc_code),
   .pending(pending), .dma_start(dma_start), .dma_kind(dma_kind),
   .fill_armed(fill_armed)
);

// File: tb/sim_vcmd_port.sv
module sim_vcmd_port;
   localparam int CLK_PERIOD = 10;
   localparam int RAND_CYCLES = 4000;

   logic        clk = 1'b0;
   logic        rst;
   logic        ctl_wr, ctl_rd, dat_wr, dat_rd, collide_evt;
   logic [15:0] ctl_wdata, ctl_rdata;
   logic [8:0]  live_flags;
   logic        reg_we, pending, dma_start, fill_armed;
   logic [4:0]  reg_idx;
   logic [7:0]  reg_val;
   logic [15:0] acc_addr;
   logic [5:0]  acc_code;
   logic [1:0]  dma_kind;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // bench model
   logic [15:0] m_addr;
   logic [1:0]  m_latch, m_mode, m_kind;
   logic [5:0]  m_code;
   logic        m_pend, m_en, m_arm, m_coll, m_we, m_start;
   logic [4:0]  m_idx;
   logic [7:0]  m_val;

   always #(CLK_PERIOD/2) clk = ~clk;

   vcmd_port u0 (
      .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_rd(ctl_rd),
      .ctl_rdata(ctl_rdata), .dat_wr(dat_wr), .dat_rd(dat_rd), .live_flags(live_flags),
      .collide_evt(collide_evt), .reg_we(reg_we), .reg_idx(reg_idx), .reg_val(reg_val),
      .acc_addr(acc_addr), .acc_code(acc_code), .pending(pending),
      .dma_start(dma_start), .dma_kind(dma_kind), .fill_armed(fill_armed)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [15:0] exp_status(input logic [8:0] lv, input logic c);
      return {6'd0, 1'b1, lv[8:7], 1'b0, c, lv[4:0]};
   endfunction

   task automatic model_reset();
      m_addr = '0; m_latch = '0; m_mode = '0; m_kind = '0; m_code = '0;
      m_pend = 0; m_en = 0; m_arm = 0; m_coll = 0; m_we = 0; m_start = 0;
      m_idx = '0; m_val = '0;
   endtask

   task automatic model_step(input logic w, input logic [15:0] d, input logic r,
                             input logic dw, input logic dr, input logic ev);
      logic isreg;
      isreg = w && !m_pend && d[15:14] == 2'b10;
      m_we = 0; m_start = 0;
      m_coll = ev ? 1'b1 : (r ? 1'b0 : m_coll);
      if (w) begin
         if (!m_pend) begin
            m_addr = {m_latch, d[13:0]};
            m_code = {m_code[5:2], d[15:14]};
            m_pend = !isreg;
            if (isreg && d[12:8] <= 5'd23) begin
               m_we = 1; m_idx = d[12:8]; m_val = d[7:0];
               if (d[12:8] == 5'd1)  m_en = d[4];
               if (d[12:8] == 5'd23) m_mode = d[7:6];
            end
         end else begin
            m_pend = 0;
            m_addr[15:14] = d[1:0];
            m_code[5:2] = d[7:4];
            m_latch = d[1:0];
            if (d[7] && m_en) begin
               if (m_mode == 2'b10) m_arm = 1;
               else begin m_start = 1; m_kind = m_mode; end
            end
         end
      end else begin
         if (r || dw || dr) m_pend = 0;
         if (dw && m_arm) begin m_start = 1; m_kind = 2'b10; m_arm = 0; end
      end
   endtask

   // one cycle: drive, check read word, advance, check registered outputs
   task automatic step(input logic w, input logic [15:0] d, input logic r,
                       input logic dw, input logic dr, input logic ev,
                       input logic [8:0] lv);
      @(negedge clk);
      ctl_wr = w; ctl_wdata = d; ctl_rd = r; dat_wr = dw; dat_rd = dr;
      collide_evt = ev; live_flags = lv;
      #1;
      chk("R7 read word", ctl_rdata, exp_status(lv, m_coll));
      model_step(w, d, r, dw, dr, ev);
      @(posedge clk);
      #1;
      chk("R1 reg strobe", {reg_we, reg_idx, reg_val}, {m_we, m_idx, m_val});
      chk("R2 addr/code", {acc_addr, acc_code}, {m_addr, m_code});
      chk("R3 pending", pending, m_pend);
      chk("R5 dma start", {dma_start, dma_kind, fill_armed}, {m_start, m_kind, m_arm});
   endtask

   task automatic idle();
      step(0, 16'h0, 0, 0, 0, 0, 9'h0);
   endtask

   initial begin
      #(CLK_PERIOD * 60000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      rst = 1; ctl_wr = 0; ctl_wdata = 0; ctl_rd = 0; dat_wr = 0; dat_rd = 0;
      collide_evt = 0; live_flags = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 0;
      model_reset();
      #1;
      chk("R10 reset state", {acc_addr, acc_code, pending, reg_we, dma_start, fill_armed},
          {16'd0, 6'd0, 1'b0, 1'b0, 1'b0, 1'b0});
      chk("R10 reset collision", ctl_rdata[5], 0);

      // enable DMA, select fill
      step(1, 16'h8114, 0, 0, 0, 0, 9'h0);
      chk("R1 reg1 strobe", {reg_we, reg_idx, reg_val}, {1'b1, 5'd1, 8'h14});
      idle();
      chk("R1 strobe one cycle", reg_we, 0);
      step(1, 16'h9780, 0, 0, 0, 0, 9'h0);
      // high index with bit 4 clear must not disable DMA
      step(1, 16'h9900, 0, 0, 0, 0, 9'h0);
      chk("R9 no strobe idx 25", reg_we, 0);
      // command: first word 0x4123, second 0x0082
      step(1, 16'h4123, 0, 0, 0, 0, 9'h0);
      chk("R2 first word", {pending, acc_addr, acc_code}, {1'b1, 16'h0123, 6'h01});
      step(1, 16'h0082, 0, 0, 0, 0, 9'h0);
      chk("R3 second word", {pending, acc_addr, acc_code}, {1'b0, 16'h8123, 6'h21});
      chk("R5 fill armed", {fill_armed, dma_start}, {1'b1, 1'b0});
      step(0, 16'h0, 0, 1, 0, 0, 9'h0);
      chk("R6 fill fires", {dma_start, dma_kind, fill_armed}, {1'b1, 2'b10, 1'b0});
      // latched pair reused
      step(1, 16'h0004, 0, 0, 0, 0, 9'h0);
      chk("R2 latched pair", acc_addr, 16'h8004);
      step(0, 16'h0, 0, 0, 1, 0, 9'h0);
      chk("R8 data read clears", pending, 0);
      // copy mode
      step(1, 16'h97C0, 0, 0, 0, 0, 9'h0);
      step(1, 16'h4000, 0, 0, 0, 0, 9'h0);
      step(1, 16'h00C0, 0, 0, 0, 0, 9'h0);
      chk("R5 copy start", {dma_start, dma_kind}, {1'b1, 2'b11});
      // no code bit 5
      step(1, 16'h4000, 0, 0, 0, 0, 9'h0);
      step(1, 16'h0040, 0, 0, 0, 0, 9'h0);
      chk("R4 no dma without code bit", dma_start, 0);
      // collision + read
      step(0, 16'h0, 0, 0, 0, 1, 9'h1FF);
      step(0, 16'h0, 1, 0, 0, 0, 9'h1FF);
      step(0, 16'h0, 1, 0, 0, 0, 9'h000);
      chk("R7 collision cleared", ctl_rdata, 16'h0200);
      // write + read same cycle
      step(1, 16'h4444, 1, 0, 1, 0, 9'h0);
      chk("R11 write wins", pending, 1);
      step(0, 16'h0, 1, 0, 0, 0, 9'h0);
      chk("R7 read clears pending", pending, 0);

      for (int i = 0; i < RAND_CYCLES; i++) begin
         logic        w, r, dw, dr, ev;
         logic [15:0] d;
         logic [4:0]  ix;
         w  = ($urandom % 10) < 4;
         r  = ($urandom % 100) < 15;
         dw = ($urandom % 100) < 10;
         dr = ($urandom % 100) < 10;
         ev = ($urandom % 100) < 10;
         d  = 16'($urandom);
         if (($urandom % 3) == 0) begin
            case ($urandom % 4)
               0: ix = 5'd1;
               1: ix = 5'd23;
               default: ix = 5'($urandom);
            endcase
            d = {3'b100, ix, d[7:0]};
         end
         step(w, d, r, dw, dr, ev, 9'($urandom));
      end

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule